// File: doc/BRIEF.md
# ROM Checksum Sequencer

This block computes a 16-bit signature over the used part of a program memory holding 14-bit words. A single start pulse, together with a start address equal to the code length, sets it walking downward from that address to address zero through a synchronous ROM read port. Each fetched word is folded into the signature in three steps. First its low byte is XOR-ed into the low half. Then its high part is added into the high half. Finally the whole 16-bit value is rotated left by one.

When the walk ends the block raises `done` and holds the signature steady until the next start. It also counts every clock spent on the walk. An external tester can read this count to time the run. Each word always takes the same number of cycles, so the count follows directly from the code length.

The ROM port uses a fixed latency and has no back-pressure. A read strobe goes out with an address, and the word is expected on `rom_data` one clock later. The other pins are plain control and status levels.

Top module: `rom_cksum_seq`

## Requirements
- R1: A start pulse seen while idle is accepted at that clock edge. From the next cycle `busy` is 1, `done` is 0, `signature` is 0x0000 and `cycles` is 0 or counting up from 0.
- R2: Each word is read with a single one-cycle `rom_en` strobe. The first address is the start address N, and each later address is one below the one before, down to 0. A walk makes exactly N+1 reads.
- R3: For every word, the word's bits 7:0 are XOR-ed into the signature low half (signature bits 7:0). For example, with N=0 and the word 0x00A5, the result is 0x014A.
- R4: For every word, the value {fill, word bits 13:8} is added modulo 256 into the high half (signature bits 15:8). Fill is two bits that are all zero or all one, chosen by the parameter `FILL_ONES` (default 0). For example, with N=0 and the word 0x3F00, the result is 0x7E00.
- R5: After the XOR and the add for each word, the 16-bit {high, low} value is rotated left by one. The bit leaving bit 15 re-enters at bit 0. For example, with N=2 and every word 0x2000, the result is 0xC001.
- R6: Each word takes exactly three clocks: issue, wait and fold. `done` rises 3·(N+1) clocks after the accepting edge, and `busy` falls at the same edge. After that, `done`, `signature` and `cycles` hold until the next accepted start.
- R7: `cycles` equals the number of clocks from the accepting edge to the edge that raises `done`, which is 3·(N+1). It saturates at 0xFFFF and never wraps.
- R8: A start pulse while `busy` is 1 is ignored. It changes neither the walk, the read addresses, the signature nor the cycle count.
- R9: With N=0x0055 and the bench's reference ROM image, the signature equals the one given by an independent software model of R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only while idle |
| start_addr | input | 16 | Code length N; the highest address walked |
| rom_en | output | 1 | ROM read strobe, one cycle per word |
| rom_addr | output | 16 | ROM read address |
| rom_data | input | 14 | ROM word, valid one clock after `rom_en` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished; result held |
| signature | output | 16 | {high half, low half} of the signature |
| cycles | output | 16 | Clocks spent on the last walk, saturating |

## Verification
Because every word passes through the rotate, a single wrong bit in either half, or one wrong step of the address counter, spreads into the final `signature`. It therefore shows up there by the `done` edge at the latest. A wrong address step is visible one word earlier, on the `rom_addr` value that comes with the next `rom_en` strobe. A state machine that drops or adds a state moves the rise of `done` and the value of `cycles` by a whole multiple of the word count. That is seen at the end of the first walk. A start that is not properly ignored shows as a repeated or out-of-order read address within three clocks.

// File: rtl/ckseq_pkg.sv
package ckseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FOLD  = 2'd3
  } walk_state_e;

endpackage

// File: rtl/ckseq_ctrl.sv
module ckseq_ctrl
  import ckseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        at_zero,
  output walk_state_e state,
  output logic        accept,
  output logic        finish,
  output logic        done
);

  walk_state_e state_nx;

  assign accept = (state == ST_IDLE) && start;
  assign finish = (state == ST_FOLD) && at_zero;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start) state_nx = ST_ISSUE;
      ST_ISSUE: state_nx = ST_WAIT;
      ST_WAIT:  state_nx = ST_FOLD;
      ST_FOLD:  state_nx = at_zero ? ST_IDLE : ST_ISSUE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept)      done <= 1'b0;
      else if (finish) done <= 1'b1;
    end
  end

  // R8: once running, only the final fold may return to idle
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !finish) |=> (state != ST_IDLE));

  // R6: done is never shown while a walk is in progress
  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> !done);

endmodule

// File: rtl/ckseq_walker.sv
module ckseq_walker #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              at_zero
);

  assign at_zero = (addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                addr <= '0;
    else if (load)             addr <= load_addr;
    else if (step && !at_zero) addr <= addr - 1'b1;
  end

  // R2: every fold that does not end the walk moves the address down by one
  p_addr_desc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero && !load) |=> (addr == $past(addr) - 1'b1));

endmodule

// File: rtl/ckseq_fold.sv
module ckseq_fold #(
  parameter int WORD_W    = 14,
  parameter int HALF_W    = 8,
  parameter bit FILL_ONES = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                capture,
  input  logic [WORD_W-1:0]   rom_data,
  input  logic                step,
  output logic [2*HALF_W-1:0] signature
);

  localparam int HI_W   = WORD_W - HALF_W;
  localparam int FILL_W = HALF_W - HI_W;

  logic [WORD_W-1:0]   word_q;
  logic [HALF_W-1:0]   lo_q, hi_q;
  logic [HALF_W-1:0]   w_lo, w_hi;
  logic [HALF_W-1:0]   lo_mix, hi_mix;
  logic [2*HALF_W-1:0] rot;

  assign w_lo = word_q[HALF_W-1:0];

  generate
    if (FILL_W > 0) begin : g_fill
      assign w_hi = {{FILL_W{FILL_ONES}}, word_q[WORD_W-1:HALF_W]};
    end else begin : g_nofill
      assign w_hi = word_q[2*HALF_W-1:HALF_W];
    end
  endgenerate

  assign lo_mix = lo_q ^ w_lo;
  assign hi_mix = hi_q + w_hi;
  assign rot    = {hi_mix[HALF_W-2:0], lo_mix, hi_mix[HALF_W-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (capture) word_q <= rom_data;
      if (clear) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (step) begin
        hi_q <= rot[2*HALF_W-1:HALF_W];
        lo_q <= rot[HALF_W-1:0];
      end
    end
  end

  assign signature = {hi_q, lo_q};

  // R1: an accepted start leaves the signature at zero
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (signature == '0));

  // R6: the signature only moves on a fold
  p_sig_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(signature));

endmodule

// File: rtl/ckseq_timer.sv
module ckseq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  output logic [CNT_W-1:0] cycles
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cycles <= '0;
    else if (clear)                    cycles <= '0;
    else if (run && cycles != CNT_MAX) cycles <= cycles + 1'b1;
  end

  // R7: a saturated count never wraps to zero
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && cycles == CNT_MAX) |=> (cycles == CNT_MAX));

endmodule

// File: rtl/rom_cksum_seq.sv
module rom_cksum_seq
  import ckseq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 14,
  parameter int HALF_W    = 8,
  parameter int CNT_W     = 16,
  parameter bit FILL_ONES = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  output logic                rom_en,
  output logic [ADDR_W-1:0]   rom_addr,
  input  logic [WORD_W-1:0]   rom_data,
  output logic                busy,
  output logic                done,
  output logic [2*HALF_W-1:0] signature,
  output logic [CNT_W-1:0]    cycles
);

  walk_state_e state;
  logic        accept, finish, at_zero;
  logic [ADDR_W-1:0] addr;

  ckseq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .at_zero (at_zero),
    .state   (state),
    .accept  (accept),
    .finish  (finish),
    .done    (done)
  );

  ckseq_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_addr (start_addr),
    .step      (state == ST_FOLD),
    .addr      (addr),
    .at_zero   (at_zero)
  );

  ckseq_fold #(
    .WORD_W    (WORD_W),
    .HALF_W    (HALF_W),
    .FILL_ONES (FILL_ONES)
  ) u_fold (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .capture   (state == ST_WAIT),
    .rom_data  (rom_data),
    .step      (state == ST_FOLD),
    .signature (signature)
  );

  ckseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .run    (busy),
    .cycles (cycles)
  );

  assign busy     = (state != ST_IDLE);
  assign rom_en   = (state == ST_ISSUE);
  assign rom_addr = addr;

  // R2: a read strobe never lasts two cycles
  p_one_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |=> !rom_en);

  // R6: while done stays high the result and count stay put
  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(signature) && $stable(cycles)));

endmodule

// File: tb/sim_rom_cksum_seq.sv
module sim_rom_cksum_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] start_addr;
  logic        rom_en;
  logic [15:0] rom_addr;
  logic [13:0] rom_data;
  logic        busy, done;
  logic [15:0] signature, cycles;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit          img_fixed = 1'b0;
  logic [13:0] fixed_word = '0;
  logic [13:0] img_key = '0;

  int mon_exp = 0;
  int mon_reads = 0;
  int mon_bad = 0;

  always #10 clk = ~clk;

  rom_cksum_seq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .rom_en     (rom_en),
    .rom_addr   (rom_addr),
    .rom_data   (rom_data),
    .busy       (busy),
    .done       (done),
    .signature  (signature),
    .cycles     (cycles)
  );

  function automatic logic [13:0] rom_word(input logic [15:0] a);
    logic [15:0] h;
    if (img_fixed) return fixed_word;
    h = (a * 16'd37) ^ (a << 5) ^ 16'h0155;
    return h[13:0] ^ img_key;
  endfunction

  always @(posedge clk) if (rom_en) rom_data <= rom_word(rom_addr);

  always @(negedge clk) begin
    if (rom_en) begin
      if (int'(rom_addr) != mon_exp) mon_bad++;
      mon_exp--;
      mon_reads++;
    end
  end

  function automatic logic [15:0] sig_model(input int n);
    logic [7:0]  lo = 8'h00;
    logic [7:0]  hi = 8'h00;
    logic [13:0] w;
    logic [15:0] r;
    for (int a = n; a >= 0; a--) begin
      w  = rom_word(16'(a));
      lo = lo ^ w[7:0];
      hi = hi + {2'b00, w[13:8]};
      r  = {hi, lo};
      r  = {r[14:0], r[15]};
      hi = r[15:8];
      lo = r[7:0];
    end
    return {hi, lo};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_walk(input int n, input bit poke, input logic [15:0] lit_exp,
                          input bit use_lit, input string req);
    int k;
    int exp_cyc;
    logic [15:0] exp_sig;
    logic [15:0] held_sig, held_cyc;
    exp_sig = use_lit ? lit_exp : sig_model(n);
    exp_cyc = 3 * (n + 1);
    if (exp_cyc > 65535) exp_cyc = 65535;
    @(negedge clk);
    start_addr = 16'(n);
    start = 1'b1;
    mon_exp = n;
    mon_reads = 0;
    mon_bad = 0;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    check("R1", "busy after accept", {31'd0, busy}, 32'd1);
    check("R1", "signature cleared", {16'd0, signature}, 32'd0);
    while (!done && k < 100000) begin
      if (poke && k == 4) begin
        start = 1'b1;
        start_addr = 16'(n + 7);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check("R6", "clocks to done", k, 3 * (n + 1) + 1);
    check("R6", "busy low at done", {31'd0, busy}, 32'd0);
    check("R7", "cycle count", {16'd0, cycles}, exp_cyc);
    check("R2", "read count", mon_reads, n + 1);
    check("R2", "address order errors", mon_bad, 0);
    check(req, "signature", {16'd0, signature}, {16'd0, exp_sig});
    held_sig = signature;
    held_cyc = cycles;
    repeat (5) @(negedge clk);
    check("R6", "done held", {31'd0, done}, 32'd1);
    check("R6", "signature held", {16'd0, signature}, {16'd0, held_sig});
    check("R6", "cycles held", {16'd0, cycles}, {16'd0, held_cyc});
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start = 1'b0;
    start_addr = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset busy", {31'd0, busy}, 32'd0);
    check("R1", "reset done", {31'd0, done}, 32'd0);
    check("R1", "reset signature", {16'd0, signature}, 32'd0);
    check("R1", "reset cycles", {16'd0, cycles}, 32'd0);
    check("R2", "reset rom_en", {31'd0, rom_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: single word, low byte only
    img_fixed = 1'b1;
    fixed_word = 14'h00A5;
    run_walk(0, 1'b0, 16'h014A, 1'b1, "R3");
    // R4: single word, high part only, zero fill
    fixed_word = 14'h3F00;
    run_walk(0, 1'b0, 16'h7E00, 1'b1, "R4");
    // R5: rotate wraps bit 15 into bit 0
    fixed_word = 14'h2000;
    run_walk(2, 1'b0, 16'hC001, 1'b1, "R5");

    // R9: reference image, code length 0x0055
    img_fixed = 1'b0;
    img_key = '0;
    run_walk(32'h55, 1'b0, 16'h0, 1'b0, "R9");

    // R8: start pulse during a walk is ignored
    run_walk(40, 1'b1, 16'h0, 1'b0, "R8");

    // random lengths and images
    for (int i = 0; i < 8; i++) begin
      img_key = 14'($urandom);
      run_walk(int'($urandom_range(0, 200)), (i % 2) == 1 && 1'b1, 16'h0, 1'b0, "R3");
    end

    // R7: long walk saturates the cycle count
    img_key = 14'h1555;
    run_walk(32'h6000, 1'b0, 16'h0, 1'b0, "R7");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule